// File: doc/BRIEF.md
# Hoisted-Load Alias Guard Table

This block lets a compiler move a load above stores that might write the same bytes. When a hoisted load executes, it records its byte span in a small associative table. The span is filed under the number of the load's destination register. Every later store presents its own byte span, and the table drops every record that the store touches. When execution reaches the load's original position, a check names the same register. The table answers with a hit when the record is still there, so the loaded value can be kept. It answers with a fixup request when the record was removed or never written, and the core then branches to recovery code.

The table holds a parameter number of records (16 by default). Each record has a valid flag, a 7-bit register tag, a 64-bit byte address and a 2-bit size code. A new record for a tag already in the table reuses that slot. Otherwise it takes the lowest free slot. When the table is full it evicts slots in round-robin order. A check can also run in a clearing form, which drops the record after reading it. Check answers are registered and appear one cycle after the request.

Top module: `hoist_guard`

## Requirements
- R1: After reset the table is empty. `resp_vld`, `resp_hit` and `resp_fixup` are 0, and any check answers fixup.
- R2: After an allocation for tag T, a check for T answers `resp_hit`=1. The answer appears in the cycle after the check request.
- R3: A check for a tag with no valid record answers `resp_fixup`=1.
- R4: A store drops a record when their byte spans share at least one byte. A span runs from the address to address + 2^size - 1, where size code 0/1/2/3 means 1/2/4/8 bytes. Spans that only touch end to end do not match.
- R5: A single store drops every record its span overlaps, not only the first.
- R6: An allocation for a tag that already has a valid record overwrites that record with the new address. It does not take another slot, and it does not advance the round-robin pointer.
- R7: An allocation for a new tag fills the lowest-numbered free slot. When no slot is free, it evicts slots in round-robin order, starting from slot 0 after reset.
- R8: When a store and a check arrive in the same cycle and the store overlaps the checked record, the check answers fixup and the record is dropped.
- R9: A plain check (`chk_clr`=0) leaves a hit record valid. A clearing check (`chk_clr`=1) answers from the record and then drops it.
- R10: An allocation is ordered after a store in the same cycle, so the new record stays valid. A check in the same cycle as an allocation sees the table as it was before the allocation.
- R11: Every check request gives `resp_vld`=1 in the next cycle, with exactly one of `resp_hit` and `resp_fixup` set. Without a request, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Hoisted load records its span this cycle |
| alloc_tag | input | 7 | Destination register tag of the hoisted load |
| alloc_addr | input | 64 | Byte address of the hoisted load |
| alloc_size | input | 2 | Size code of the load (0..3 = 1..8 bytes) |
| st_vld | input | 1 | Store snoop valid |
| st_addr | input | 64 | Store byte address |
| st_size | input | 2 | Store size code |
| chk_vld | input | 1 | Check request valid |
| chk_tag | input | 7 | Register tag to check |
| chk_clr | input | 1 | Drop the record after checking |
| resp_vld | output | 1 | Check answer valid (one cycle after the request) |
| resp_hit | output | 1 | Record intact, keep the speculative value |
| resp_fixup | output | 1 | Record missing or dropped, run recovery |

## Verification
The hardest state to reach is a full table where eviction order matters. It can only be observed as fixups on tags that were evicted. The stimulus fills all sixteen slots and forces two round-robin evictions. It then reallocates an existing tag and frees one slot with a clearing check. A further allocation must then evict the slot the pointer still holds. Same-cycle collisions are driven in one cycle each: a store with a check, and a store with an allocation. Each collision is followed by a second check that shows what the table kept.

// File: rtl/hoist_guard_pkg.sv
package hoist_guard_pkg;

    localparam int HG_TAG_W  = 7;
    localparam int HG_ADDR_W = 64;
    localparam int HG_SIZE_W = 2;

    // byte span of an access: address plus log2 of its byte count
    typedef struct packed {
        logic [HG_ADDR_W-1:0] addr;
        logic [HG_SIZE_W-1:0] size;
    } span_t;

    // one record of the guard table
    typedef struct packed {
        logic                 vld;
        logic [HG_TAG_W-1:0]  tag;
        span_t                span;
    } entry_t;

    typedef enum logic [1:0] {
        PICK_SAME = 2'd0,
        PICK_FREE = 2'd1,
        PICK_RR   = 2'd2
    } pick_e;

    // last byte covered by a span, one bit wider to avoid wrap
    function automatic logic [HG_ADDR_W:0] span_last(span_t s);
        logic [HG_ADDR_W:0] len;
        len = {{HG_ADDR_W{1'b0}}, 1'b1} << s.size;
        return {1'b0, s.addr} + len - 1'b1;
    endfunction

    function automatic logic spans_overlap(span_t a, span_t b);
        return ({1'b0, a.addr} <= span_last(b)) &&
               ({1'b0, b.addr} <= span_last(a));
    endfunction

endpackage

// File: rtl/hg_cam.sv
module hg_cam
    import hoist_guard_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  entry_t [ENTRIES-1:0] ents,
    input  logic [HG_TAG_W-1:0]  a_tag,
    input  logic [HG_TAG_W-1:0]  c_tag,
    input  span_t                st_span,
    output logic [ENTRIES-1:0]   a_hit,
    output logic [ENTRIES-1:0]   c_hit,
    output logic [ENTRIES-1:0]   s_hit
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        assign a_hit[i] = ents[i].vld && (ents[i].tag == a_tag);
        assign c_hit[i] = ents[i].vld && (ents[i].tag == c_tag);
        assign s_hit[i] = ents[i].vld && spans_overlap(ents[i].span, st_span);
    end

endmodule

// File: rtl/hg_victim.sv
module hg_victim
    import hoist_guard_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_vld,
    input  logic [ENTRIES-1:0] same_hit,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] same_idx, free_idx;
    logic             same_any, free_any;
    pick_e            pick;

    always_comb begin
        same_idx = '0;
        same_any = 1'b0;
        free_idx = '0;
        free_any = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (same_hit[i] && !same_any) begin
                same_idx = IDX_W'(i);
                same_any = 1'b1;
            end
            if (!valid_vec[i] && !free_any) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    always_comb begin
        if (same_any) begin
            pick   = PICK_SAME;
            victim = same_idx;
        end else if (free_any) begin
            pick   = PICK_FREE;
            victim = free_idx;
        end else begin
            pick   = PICK_RR;
            victim = rr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (alloc_vld && pick == PICK_RR) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/hg_resp.sv
module hg_resp #(
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chk_vld,
    input  logic               st_vld,
    input  logic [ENTRIES-1:0] c_hit,
    input  logic [ENTRIES-1:0] s_hit,
    output logic               resp_vld,
    output logic               resp_hit,
    output logic               resp_fixup
);

    logic [ENTRIES-1:0] killed;
    logic               intact;

    // a store in the same cycle wins over the check
    assign killed = st_vld ? s_hit : '0;
    assign intact = |(c_hit & ~killed);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_vld   <= 1'b0;
            resp_hit   <= 1'b0;
            resp_fixup <= 1'b0;
        end else begin
            resp_vld   <= chk_vld;
            resp_hit   <= chk_vld && intact;
            resp_fixup <= chk_vld && !intact;
        end
    end

endmodule

// File: rtl/hoist_guard.sv
module hoist_guard
    import hoist_guard_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = HG_TAG_W,
    parameter int ADDR_W  = HG_ADDR_W,
    parameter int SIZE_W  = HG_SIZE_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_vld,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [SIZE_W-1:0] alloc_size,
    input  logic              st_vld,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              chk_vld,
    input  logic [TAG_W-1:0]  chk_tag,
    input  logic              chk_clr,
    output logic              resp_vld,
    output logic              resp_hit,
    output logic              resp_fixup
);

    entry_t [ENTRIES-1:0] tbl_q;
    logic   [ENTRIES-1:0] valid_vec, a_hit, c_hit, s_hit;
    logic   [IDX_W-1:0]   victim;
    span_t                st_span;
    entry_t               new_ent;

    assign st_span = '{addr: st_addr, size: st_size};
    assign new_ent = '{vld: 1'b1, tag: alloc_tag,
                       span: '{addr: alloc_addr, size: alloc_size}};

    for (genvar i = 0; i < ENTRIES; i++) begin : g_vld
        assign valid_vec[i] = tbl_q[i].vld;
    end

    hg_cam #(.ENTRIES(ENTRIES)) u_cam (
        .ents    (tbl_q),
        .a_tag   (alloc_tag),
        .c_tag   (chk_tag),
        .st_span (st_span),
        .a_hit   (a_hit),
        .c_hit   (c_hit),
        .s_hit   (s_hit)
    );

    hg_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .alloc_vld (alloc_vld),
        .same_hit  (a_hit),
        .valid_vec (valid_vec),
        .victim    (victim)
    );

    hg_resp #(.ENTRIES(ENTRIES)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .chk_vld    (chk_vld),
        .st_vld     (st_vld),
        .c_hit      (c_hit),
        .s_hit      (s_hit),
        .resp_vld   (resp_vld),
        .resp_hit   (resp_hit),
        .resp_fixup (resp_fixup)
    );

    // same-cycle order: store drop, clearing check drop, then allocation write
    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (st_vld && s_hit[i]) begin
                    tbl_q[i].vld <= 1'b0;
                end
                if (chk_vld && chk_clr && c_hit[i]) begin
                    tbl_q[i].vld <= 1'b0;
                end
                if (alloc_vld && victim == IDX_W'(i)) begin
                    tbl_q[i] <= new_ent;
                end
            end
        end
    end

endmodule

// File: rtl/hg_chk.sv
module hg_chk #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               alloc_vld,
    input logic               st_vld,
    input logic               chk_vld,
    input logic               resp_vld,
    input logic               resp_hit,
    input logic               resp_fixup,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] a_hit,
    input logic [ENTRIES-1:0] c_hit,
    input logic [ENTRIES-1:0] s_hit
);

    // R1
    reset_empties_chk: assert property (@(posedge clk)
        rst |=> (valid_vec == '0) && !resp_vld);

    // R11
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        chk_vld |=> resp_vld);

    // R11
    resp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        resp_vld |-> $onehot({resp_hit, resp_fixup}));

    // R11
    resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !resp_vld |-> !resp_hit && !resp_fixup);

    // R8
    store_beats_check_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_vld && st_vld && |(c_hit & s_hit)) |=> resp_fixup);

    // R6
    one_slot_per_tag_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(c_hit) && $onehot0(a_hit));

    // R4
    store_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (st_vld && !alloc_vld) |=> ((valid_vec & $past(s_hit)) == '0));

    // R10
    alloc_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_vld |=> (valid_vec != '0));

endmodule

bind hoist_guard hg_chk #(.ENTRIES(ENTRIES)) u_hg_chk (
    .clk        (clk),
    .rst        (rst),
    .alloc_vld  (alloc_vld),
    .st_vld     (st_vld),
    .chk_vld    (chk_vld),
    .resp_vld   (resp_vld),
    .resp_hit   (resp_hit),
    .resp_fixup (resp_fixup),
    .valid_vec  (valid_vec),
    .a_hit      (a_hit),
    .c_hit      (c_hit),
    .s_hit      (s_hit)
);

// File: tb/hoist_guard_test.sv
module hoist_guard_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_vld = 1'b0;
    logic [6:0]  alloc_tag = '0;
    logic [63:0] alloc_addr = '0;
    logic [1:0]  alloc_size = '0;
    logic        st_vld = 1'b0;
    logic [63:0] st_addr = '0;
    logic [1:0]  st_size = '0;
    logic        chk_vld = 1'b0;
    logic [6:0]  chk_tag = '0;
    logic        chk_clr = 1'b0;
    logic        resp_vld, resp_hit, resp_fixup;

    int checks = 0;
    int errors = 0;
    logic g_vld, g_hit, g_fix;

    always #10 clk = ~clk;

    hoist_guard uut (
        .clk(clk), .rst(rst),
        .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
        .alloc_addr(alloc_addr), .alloc_size(alloc_size),
        .st_vld(st_vld), .st_addr(st_addr), .st_size(st_size),
        .chk_vld(chk_vld), .chk_tag(chk_tag), .chk_clr(chk_clr),
        .resp_vld(resp_vld), .resp_hit(resp_hit), .resp_fixup(resp_fixup)
    );

    localparam logic [1:0] OP_A = 2'd0, OP_S = 2'd1, OP_C = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [6:0]  tag;
        logic [63:0] addr;
        logic [1:0]  sz;
        logic        clr;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{OP_A, 7'd5, 64'h1000, 2'd3, 1'b0, 1'b0, 4'd2},
        '{OP_C, 7'd5, 64'h0,    2'd0, 1'b0, 1'b1, 4'd2},  // R2
        '{OP_C, 7'd9, 64'h0,    2'd0, 1'b0, 1'b0, 4'd3},  // R3
        '{OP_S, 7'd0, 64'h1008, 2'd3, 1'b0, 1'b0, 4'd4},
        '{OP_C, 7'd5, 64'h0,    2'd0, 1'b0, 1'b1, 4'd4},  // R4 adjacent
        '{OP_S, 7'd0, 64'h1006, 2'd2, 1'b0, 1'b0, 4'd4},
        '{OP_C, 7'd5, 64'h0,    2'd0, 1'b0, 1'b0, 4'd4},  // R4 partial
        '{OP_A, 7'd5, 64'h2000, 2'd0, 1'b0, 1'b0, 4'd5},
        '{OP_A, 7'd6, 64'h2001, 2'd0, 1'b0, 1'b0, 4'd5},
        '{OP_A, 7'd7, 64'h1FFE, 2'd2, 1'b0, 1'b0, 4'd5},
        '{OP_S, 7'd0, 64'h2000, 2'd1, 1'b0, 1'b0, 4'd5},
        '{OP_C, 7'd5, 64'h0,    2'd0, 1'b0, 1'b0, 4'd5},  // R5
        '{OP_C, 7'd6, 64'h0,    2'd0, 1'b0, 1'b0, 4'd5},
        '{OP_C, 7'd7, 64'h0,    2'd0, 1'b0, 1'b0, 4'd5},
        '{OP_A, 7'd8, 64'h3000, 2'd3, 1'b0, 1'b0, 4'd6},
        '{OP_A, 7'd8, 64'h4000, 2'd3, 1'b0, 1'b0, 4'd6},
        '{OP_S, 7'd0, 64'h3000, 2'd3, 1'b0, 1'b0, 4'd6},
        '{OP_C, 7'd8, 64'h0,    2'd0, 1'b0, 1'b1, 4'd6},  // R6
        '{OP_C, 7'd8, 64'h0,    2'd0, 1'b0, 1'b1, 4'd9},  // R9 plain
        '{OP_C, 7'd8, 64'h0,    2'd0, 1'b1, 1'b1, 4'd9},  // R9 clearing
        '{OP_C, 7'd8, 64'h0,    2'd0, 1'b0, 1'b0, 4'd9}
    };

    task automatic cyc(input logic av, input logic [6:0] at, input logic [63:0] aa,
                       input logic [1:0] as, input logic sv, input logic [63:0] sa,
                       input logic [1:0] ss, input logic cv, input logic [6:0] ct,
                       input logic cc);
        @(negedge clk);
        alloc_vld = av; alloc_tag = at; alloc_addr = aa; alloc_size = as;
        st_vld = sv; st_addr = sa; st_size = ss;
        chk_vld = cv; chk_tag = ct; chk_clr = cc;
        @(negedge clk);
        g_vld = resp_vld; g_hit = resp_hit; g_fix = resp_fixup;
        alloc_vld = 1'b0; st_vld = 1'b0; chk_vld = 1'b0; chk_clr = 1'b0;
    endtask

    task automatic expect_resp(input string req, input logic exp_hit);
        checks++;
        if (!(g_vld === 1'b1 && g_hit === exp_hit && g_fix === !exp_hit)) begin
            errors++;
            $display("FAIL %s: got vld=%b hit=%b fixup=%b expected vld=1 hit=%b fixup=%b",
                     req, g_vld, g_hit, g_fix, exp_hit, !exp_hit);
        end
    endtask

    task automatic alloc(input logic [6:0] t, input logic [63:0] a, input logic [1:0] s);
        cyc(1'b1, t, a, s, 1'b0, '0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic check(input string req, input logic [6:0] t, input logic c,
                         input logic exp_hit);
        cyc(1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b1, t, c);
        expect_resp(req, exp_hit);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset outputs idle
        checks++;
        if (resp_vld !== 1'b0 || resp_hit !== 1'b0 || resp_fixup !== 1'b0) begin
            errors++;
            $display("FAIL R1: got vld=%b hit=%b fixup=%b expected 0 0 0",
                     resp_vld, resp_hit, resp_fixup);
        end
        check("R1", 7'd5, 1'b0, 1'b0);

        // R11 no request -> idle response
        cyc(1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
        checks++;
        if (g_vld !== 1'b0 || g_hit !== 1'b0 || g_fix !== 1'b0) begin
            errors++;
            $display("FAIL R11: got vld=%b hit=%b fixup=%b expected 0 0 0",
                     g_vld, g_hit, g_fix);
        end

        for (int k = 0; k < NV; k++) begin
            case (VECS[k].op)
                OP_A: alloc(VECS[k].tag, VECS[k].addr, VECS[k].sz);
                OP_S: cyc(1'b0, '0, '0, '0, 1'b1, VECS[k].addr, VECS[k].sz,
                          1'b0, '0, 1'b0);
                default: check($sformatf("R%0d vec %0d", VECS[k].req, k),
                               VECS[k].tag, VECS[k].clr, VECS[k].exp);
            endcase
        end

        // R1 reset empties a populated table
        alloc(7'd20, 64'h9000, 2'd3);
        do_reset();
        check("R1 after reset", 7'd20, 1'b0, 1'b0);

        // R7 fill then round-robin eviction
        for (int t = 0; t < 16; t++) alloc(7'(t), 64'(t) << 8, 2'd3);
        alloc(7'd16, 64'hA000, 2'd3);
        check("R7 slot0 evicted", 7'd0, 1'b0, 1'b0);
        check("R7 slot1 kept", 7'd1, 1'b0, 1'b1);
        check("R7 new tag", 7'd16, 1'b0, 1'b1);
        alloc(7'd17, 64'hA100, 2'd3);
        check("R7 slot1 evicted", 7'd1, 1'b0, 1'b0);
        // R6 realloc does not move pointer; R9 clear frees slot 5
        alloc(7'd3, 64'hB000, 2'd3);
        check("R9 clearing", 7'd5, 1'b1, 1'b1);
        alloc(7'd18, 64'hA200, 2'd3);
        alloc(7'd19, 64'hA300, 2'd3);
        check("R7 slot2 evicted", 7'd2, 1'b0, 1'b0);
        check("R6 realloc kept", 7'd3, 1'b0, 1'b1);
        check("R6 no extra evict", 7'd4, 1'b0, 1'b1);
        check("R7 free slot fill", 7'd18, 1'b0, 1'b1);
        check("R7 rr victim", 7'd19, 1'b0, 1'b1);
        check("R7 other kept", 7'd6, 1'b0, 1'b1);

        // R8 store and check collide
        do_reset();
        alloc(7'd30, 64'h5000, 2'd3);
        cyc(1'b0, '0, '0, '0, 1'b1, 64'h5004, 2'd0, 1'b1, 7'd30, 1'b0);
        expect_resp("R8 collide", 1'b0);
        check("R8 dropped", 7'd30, 1'b0, 1'b0);
        alloc(7'd31, 64'h6000, 2'd3);
        cyc(1'b0, '0, '0, '0, 1'b1, 64'h7000, 2'd3, 1'b1, 7'd31, 1'b0);
        expect_resp("R8 disjoint", 1'b1);

        // R10 store with alloc; check with alloc
        cyc(1'b1, 7'd40, 64'h8000, 2'd3, 1'b1, 64'h8000, 2'd3, 1'b0, '0, 1'b0);
        check("R10 alloc after store", 7'd40, 1'b0, 1'b1);
        cyc(1'b1, 7'd41, 64'h8100, 2'd3, 1'b0, '0, '0, 1'b1, 7'd41, 1'b0);
        expect_resp("R10 check sees old", 1'b0);
        check("R10 then present", 7'd41, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule